// File: doc/BRIEF.md
# Big-Endian Byte-Port Load/Store Unit

This block performs the memory operations of a small 16-bit processor against a memory whose data port is one byte wide. A request carries an opcode, a 16-bit base value, a 12-bit signed offset and 16 bits of store data. The unit adds the sign-extended offset to the base with unsigned wrap-around arithmetic. For a byte operation it makes one memory access. For a word operation it makes two accesses, with the most significant byte at the effective address and the least significant byte at the next address. When the sequence completes, it raises `done` for one cycle, and a load presents its result on `ld_data` during that cycle.

Requests arrive over a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high and the opcode is one of the four memory opcodes. `req_ready` is low for the whole time an operation is in flight, so the requester must hold or retry. A request offered while `req_ready` is low is not taken. The memory is synchronous: an access presented on the `mem_*` outputs is sampled at the next rising edge, and read data appears on `mem_rdata` after that edge. The memory side has no back-pressure.

Top module: `be_byte_lsu`

## Requirements
- R1: The effective address equals `req_base` plus `req_off` sign-extended to 16 bits, taken modulo 2^16. The first memory access of an accepted request uses this address and is presented in the cycle right after acceptance.
- R2: A word operation makes exactly two accesses in consecutive cycles, at the effective address and then at the effective address plus one. An effective address of 0xFFFF continues at 0x0000.
- R3: A load word (opcode 000010) returns the byte at the effective address in bits [15:8] and the byte at the next address in bits [7:0].
- R4: A load byte (opcode 000011) makes a single read and returns the fetched byte in bits [7:0], with bits [15:8] zero.
- R5: A store word (opcode 000100) writes `req_wdata[15:8]` in its first access, at the effective address. It writes `req_wdata[7:0]` in its second access, at the next address.
- R6: A store byte (opcode 000101) makes one write of `req_wdata[7:0]` at the effective address and leaves every other byte unchanged.
- R7: `done` is high for exactly one cycle, the cycle after the last memory access. Counted from the accepting edge, it is visible in the third cycle for word operations and in the second cycle for byte operations.
- R8: While `busy` is high, `req_ready` is low and `mem_en` is high only for the operation in flight. A request offered during that time causes no memory access and no completion.
- R9: A valid request whose opcode is not one of the four above is dropped. It causes no memory access and no `done`, and `req_ready` stays high.
- R10: After reset, `req_ready` is high and `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 6 | Opcode: 000010 LW, 000011 LB, 000100 SW, 000101 SB |
| req_base | input | 16 | Base address value |
| req_off | input | 12 | Signed offset |
| req_wdata | input | 16 | Store data |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| ld_data | output | 16 | Load result, valid while done is high, zero otherwise |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read access |

## Verification
The hardest cases to reach through the ports are the wrap from 0xFFFF to 0x0000 in the middle of a word access, and a second request that arrives while a word is still in flight. Random base values are biased toward the top and bottom of the address space. Directed cases place a word load and a word store exactly at 0xFFFF, one of them reaching it through a negative offset. A further directed case holds a conflicting store request valid for the whole duration of a word operation, then confirms that no extra access occurred and that the targeted byte kept its value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [5:0] {
    OP_LD_WORD = 6'b000010,
    OP_LD_BYTE = 6'b000011,
    OP_ST_WORD = 6'b000100,
    OP_ST_BYTE = 6'b000101
  } mem_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FIRST,
    S_SECOND,
    S_FINISH
  } seq_state_e;

  typedef struct packed {
    logic is_word;
    logic is_store;
  } op_kind_t;

  function automatic logic op_known(input logic [5:0] op);
    return (op == OP_LD_WORD) || (op == OP_LD_BYTE) ||
           (op == OP_ST_WORD) || (op == OP_ST_BYTE);
  endfunction

  function automatic op_kind_t op_decode(input logic [5:0] op);
    op_kind_t k;
    k.is_word  = (op == OP_LD_WORD) || (op == OP_ST_WORD);
    k.is_store = (op == OP_ST_WORD) || (op == OP_ST_BYTE);
    return k;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] addr_q;

  generate
    if (OFF_W < ADDR_W) begin : g_extend
      assign off_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= base + off_ext;
    end else if (step) begin
      addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  op_kind_t kind_in,
  output op_kind_t kind,
  output logic     step_addr,
  output logic     cap_hi,
  output logic     in_second,
  output logic     mem_en,
  output logic     mem_we,
  output logic     busy,
  output logic     done
);

  seq_state_e state, state_nx;
  op_kind_t   kind_q;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:   if (accept) state_nx = S_FIRST;
      S_FIRST:  state_nx = kind_q.is_word ? S_SECOND : S_FINISH;
      S_SECOND: state_nx = S_FINISH;
      S_FINISH: state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= '0;
    end else begin
      state <= state_nx;
      if (accept && state == S_IDLE) kind_q <= kind_in;
    end
  end

  assign kind      = kind_q;
  assign mem_en    = (state == S_FIRST) || (state == S_SECOND);
  assign mem_we    = mem_en && kind_q.is_store;
  assign step_addr = (state == S_FIRST) && kind_q.is_word;
  assign cap_hi    = (state == S_SECOND) && !kind_q.is_store;
  assign in_second = (state == S_SECOND);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);

endmodule

// File: rtl/lsu_lane.sv
module lsu_lane #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata_in,
  input  logic              is_word,
  input  logic              in_second,
  input  logic              cap_hi,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] ld_word
);

  logic [WORD_W-1:0] wdata_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      hi_q    <= '0;
    end else begin
      if (load)   wdata_q <= wdata_in;
      if (cap_hi) hi_q    <= mem_rdata;
    end
  end

  // Word stores send the upper byte first; byte stores use the lower byte.
  assign mem_wdata = (is_word && !in_second) ? wdata_q[WORD_W-1:BYTE_W]
                                             : wdata_q[BYTE_W-1:0];

  assign ld_word = is_word ? {hi_q, mem_rdata} : {{BYTE_W{1'b0}}, mem_rdata};

endmodule

// File: rtl/be_byte_lsu.sv
module be_byte_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [5:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ld_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  logic        accept;
  logic        step_addr;
  logic        cap_hi;
  logic        in_second;
  op_kind_t    kind;
  logic [WORD_W-1:0] ld_word;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready && op_known(req_op);

  lsu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind_in   (op_decode(req_op)),
    .kind      (kind),
    .step_addr (step_addr),
    .cap_hi    (cap_hi),
    .in_second (in_second),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done)
  );

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (step_addr),
    .base  (req_base),
    .off   (req_off),
    .addr  (mem_addr)
  );

  lsu_lane #(.BYTE_W(BYTE_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .wdata_in  (req_wdata),
    .is_word   (kind.is_word),
    .in_second (in_second),
    .cap_hi    (cap_hi),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .ld_word   (ld_word)
  );

  assign ld_data = (done && !kind.is_store) ? ld_word : '0;

endmodule

// File: rtl/be_byte_lsu_chk.sv
module be_byte_lsu_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [5:0]        req_op,
  input logic [ADDR_W-1:0] req_base,
  input logic [OFF_W-1:0]  req_off,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [ADDR_W-1:0] c_off_ext;
  logic              c_known;

  generate
    if (OFF_W < ADDR_W) begin : g_cx
      assign c_off_ext = {{(ADDR_W-OFF_W){req_off[OFF_W-1]}}, req_off};
    end else begin : g_ct
      assign c_off_ext = req_off[ADDR_W-1:0];
    end
  endgenerate

  assign c_known = (req_op == 6'b000010) || (req_op == 6'b000011) ||
                   (req_op == 6'b000100) || (req_op == 6'b000101);

  p_first_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && c_known) |=>
      (mem_en && mem_addr == $past(req_base + c_off_ext)));

  p_next_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_en) && !mem_en));

  p_ready_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  p_drop_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !c_known) |=> (!mem_en && !busy));

endmodule

bind be_byte_lsu be_byte_lsu_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_base  (req_base),
  .req_off   (req_off),
  .busy      (busy),
  .done      (done),
  .mem_en    (mem_en),
  .mem_addr  (mem_addr)
);

// File: tb/be_byte_lsu_tb.sv
module be_byte_lsu_tb;

  localparam logic [5:0] LW = 6'b000010;
  localparam logic [5:0] LB = 6'b000011;
  localparam logic [5:0] SW = 6'b000100;
  localparam logic [5:0] SB = 6'b000101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = '0;
  logic [15:0] req_base = '0;
  logic [11:0] req_off = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] ld_data, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem     [logic [15:0]];
  logic [7:0]  ref_mem [logic [15:0]];
  logic [15:0] log_addr [8];
  logic        log_we   [8];
  logic [7:0]  log_wd   [8];
  int          n_acc = 0;

  always #4 clk = ~clk;

  be_byte_lsu u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_off(req_off), .req_wdata(req_wdata),
    .busy(busy), .done(done), .ld_data(ld_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural byte memory with one-cycle read latency, plus access log.
  always @(posedge clk) begin
    if (mem_en) begin
      if (n_acc < 8) begin
        log_addr[n_acc] = mem_addr;
        log_we[n_acc]   = mem_we;
        log_wd[n_acc]   = mem_wdata;
      end
      n_acc = n_acc + 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    end
  end

  initial begin
    #1_000_000;
    errors = errors + 1;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ea_of(input logic [15:0] b, input logic [11:0] o);
    return b + {{4{o[11]}}, o};
  endfunction

  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic seed_byte(input logic [15:0] a);
    logic [7:0] v;
    if (!ref_mem.exists(a)) begin
      v = 8'($urandom);
      ref_mem[a] = v;
      mem[a]     = v;
    end
  endtask

  // Issue one request; optionally hold a conflicting store valid while busy.
  task automatic run_op(input logic [5:0] op, input logic [15:0] base,
                        input logic [11:0] off, input logic [15:0] wd,
                        input bit inject);
    logic [15:0] ea, ea1, exp_ld, got_ld;
    logic [7:0]  inj_old;
    bit          is_word, is_store;
    int          lat, exp_n;
    ea = ea_of(base, off);
    ea1 = ea + 16'd1;
    is_word  = (op == LW) || (op == SW);
    is_store = (op == SW) || (op == SB);
    seed_byte(ea);
    seed_byte(ea1);
    seed_byte(16'h0100);
    inj_old = rd_ref(16'h0100);
    exp_ld = (op == LW) ? {rd_ref(ea), rd_ref(ea1)} :
             (op == LB) ? {8'h00, rd_ref(ea)} : 16'h0000;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_off = off; req_wdata = wd;
    n_acc = 0;
    @(posedge clk);
    @(negedge clk);
    if (inject) begin
      req_op = SB; req_base = 16'h0100; req_off = 12'h000; req_wdata = 16'h5A5A;
      check(busy && !req_ready, "R8", "ready while busy", {busy, req_ready}, 2'b10);
    end else begin
      req_valid = 1'b0;
    end
    lat = 0;
    got_ld = '0;
    for (int c = 1; c <= 6; c++) begin
      if (c > 1) @(negedge clk);
      if (done) begin lat = c; got_ld = ld_data; break; end
    end
    check(lat == (is_word ? 3 : 2), "R7", "done latency", lat, is_word ? 3 : 2);
    @(negedge clk);
    check(!done, "R7", "done pulse width", done, 0);
    req_valid = 1'b0;
    exp_n = is_word ? 2 : 1;
    check(n_acc == exp_n, is_word ? "R2" : "R4", "access count", n_acc, exp_n);
    if (n_acc >= 1) begin
      check(log_addr[0] == ea, "R1", "first address", log_addr[0], ea);
      check(log_we[0] == is_store, "R1", "first write flag", log_we[0], is_store);
    end
    if (is_word && n_acc >= 2)
      check(log_addr[1] == ea1, "R2", "second address", log_addr[1], ea1);
    if (op == SW && n_acc >= 2) begin
      check(log_wd[0] == wd[15:8], "R5", "first byte written", log_wd[0], wd[15:8]);
      check(log_wd[1] == wd[7:0], "R5", "second byte written", log_wd[1], wd[7:0]);
      ref_mem[ea] = wd[15:8];
      ref_mem[ea1] = wd[7:0];
    end
    if (op == SB) begin
      check(log_wd[0] == wd[7:0], "R6", "byte written", log_wd[0], wd[7:0]);
      ref_mem[ea] = wd[7:0];
    end
    if (op == LW) check(got_ld == exp_ld, "R3", "load word data", got_ld, exp_ld);
    if (op == LB) check(got_ld == exp_ld, "R4", "load byte data", got_ld, exp_ld);
    if (is_store) begin
      check(rd_mem(ea) == rd_ref(ea), is_word ? "R5" : "R6", "memory at ea",
            rd_mem(ea), rd_ref(ea));
      check(rd_mem(ea1) == rd_ref(ea1), is_word ? "R5" : "R6", "memory at ea+1",
            rd_mem(ea1), rd_ref(ea1));
    end
    if (inject) begin
      @(negedge clk);
      check(n_acc == exp_n, "R8", "accesses after held request", n_acc, exp_n);
      check(rd_mem(16'h0100) == inj_old, "R8", "byte under ignored store",
            rd_mem(16'h0100), inj_old);
    end
  endtask

  initial begin
    logic [5:0] ops [4];
    void'($urandom(32'h0000_1A2B));
    ops[0] = LW; ops[1] = LB; ops[2] = SW; ops[3] = SB;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready in reset", req_ready, 1);
    check(!busy && !done && !mem_en, "R10", "busy/done/en in reset",
          {busy, done, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !mem_en, "R10", "idle after reset",
          {req_ready, busy, mem_en}, 3'b100);

    // Directed corner cases.
    run_op(SW, 16'h0000, 12'hFFF, 16'hBEEF, 1'b0);   // ea 0xFFFF, wraps to 0x0000
    run_op(LW, 16'hFFFF, 12'h000, 16'h0000, 1'b0);
    run_op(LW, 16'h0FF0, 12'h801, 16'h0000, 1'b0);   // negative offset
    ref_mem[16'h0300] = 8'hFF; mem[16'h0300] = 8'hFF;
    run_op(LB, 16'h0300, 12'h000, 16'h0000, 1'b0);   // zero extension of 0xFF
    run_op(SB, 16'h0400, 12'h7FF, 16'hABCD, 1'b0);
    run_op(LW, 16'h0BFE, 12'h001, 16'h0000, 1'b0);   // reads back stored byte and neighbour
    run_op(LW, 16'h0200, 12'h010, 16'h0000, 1'b1);   // conflicting request while busy
    run_op(SW, 16'h0210, 12'h004, 16'h1357, 1'b1);

    // Dropped opcode.
    @(negedge clk);
    n_acc = 0;
    req_valid = 1'b1; req_op = 6'b000110; req_base = 16'h0100; req_off = '0;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready && !busy, "R9", "ready after unknown op", {req_ready, busy}, 2'b10);
    repeat (3) begin
      @(negedge clk);
      check(!done, "R9", "no done for unknown op", done, 0);
    end
    check(n_acc == 0, "R9", "no access for unknown op", n_acc, 0);

    // Random traffic biased to both ends of the address space.
    for (int i = 0; i < 200; i++) begin
      logic [15:0] b;
      b = {($urandom_range(0, 1) == 1) ? 8'hFF : 8'h00, 8'($urandom)};
      run_op(ops[$urandom_range(0, 3)], b, 12'($urandom), 16'($urandom),
             ($urandom_range(0, 7) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule